// File: doc/BRIEF.md
# ATA Task-File Address and Count Capture

This block is the register front end of an ATA device's task file. Byte-wide host writes arrive with a register select and a write strobe. The block keeps 8-bit copies of the count, sector, cylinder and device/head registers. From these it builds the addressing mode, a block address and a transfer length in sectors. Command decoding, data movement and the medium sit outside this block. They read its outputs once a command is issued.

In 48-bit addressing, each of the four address/count registers is written twice. A private toggle for each register sends the first and second bytes to different positions of the 48-bit address or the 16-bit count. Any device/head write that alters the three mode bits returns every toggle to its first-write state. This lets the host recover from a half-written pair. A command strobe clears the 48-bit address so that the next command starts from a clean address.

Top module: `ata_lba_capture`

## Requirements
- R1: The mode comes from the device/head register. Bit 6 clear gives CHS (`mode_chs`). Bit 6 set with bits 7 and 5 both set gives 28-bit mode (`mode_lba28`). Bit 6 set with bits 7 and 5 both clear gives 48-bit mode (`mode_lba48`). Any other pattern raises no mode flag.
- R2: The select codes are 0 count, 1 sector number, 2 cylinder low, 3 cylinder high and 4 device/head. A write updates the matching 8-bit copy one cycle later, in every mode. Codes 5 to 7 change no output.
- R3: In 48-bit mode, the first count write loads count bits 15:8 and zeroes bits 7:0. The second count write loads bits 7:0.
- R4: In 48-bit mode, the first and second writes land as follows. Sector number goes to address bits 31:24, then 7:0. Cylinder low goes to 39:32, then 15:8. Cylinder high goes to 47:40, then 23:16. Each register keeps its own toggle.
- R5: Outside 48-bit mode, writes to registers 0 to 3 leave the 48-bit address, the 16-bit count and the toggles unchanged.
- R6: A device/head write whose bits 7:5 differ from the stored bits 7:5 returns all four toggles to first-write. A write that keeps bits 7:5 keeps the toggles.
- R7: A `cmd_strobe` cycle zeroes the 48-bit address and keeps the 16-bit count. An address write in the same cycle lands on the cleared value.
- R8: In 28-bit mode, `lba_addr` is device/head bits 3:0, then cylinder high, cylinder low and sector number, from most to least significant, zero-extended. In 48-bit mode it is the captured 48-bit address. In any other mode it is zero.
- R9: `xfer_sectors` gives the transfer length. In 48-bit mode it is the 16-bit count, with 0 meaning 65536. Otherwise it is the 8-bit count copy, with 0 meaning 256.
- R10: A synchronous `rst` zeroes every register and toggle. This gives CHS mode, a zero address and a length of 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Register select (0 count, 1 sector, 2 cyl low, 3 cyl high, 4 device/head) |
| wr_data | input | 8 | Write data byte |
| cmd_strobe | input | 1 | Command issued; clears the 48-bit address |
| mode_chs | output | 1 | CHS addressing selected |
| mode_lba28 | output | 1 | 28-bit addressing selected |
| mode_lba48 | output | 1 | 48-bit addressing selected |
| lba_addr | output | 48 | Block address for the current mode |
| sect_count16 | output | 16 | 48-bit-mode sector count as captured |
| xfer_sectors | output | 17 | Transfer length in sectors after zero expansion |
| count_byte | output | 8 | Copy of the count register |
| secnum_byte | output | 8 | Copy of the sector number register |
| cyl_lo_byte | output | 8 | Copy of the cylinder low register |
| cyl_hi_byte | output | 8 | Copy of the cylinder high register |
| devhead_byte | output | 8 | Copy of the device/head register |

## Verification
The hardest state to reach from the ports is a pair left half-written when the mode bits change. A toggle is then sitting at second-write, and the toggle itself is never visible. The stimulus leaves a sector-number pair half done. It first rewrites device/head with only the drive bit changed, and the next byte must finish the pair. It then leaves another pair half done and leaves and re-enters 48-bit mode through device/head. The next byte must now land in the first-write position, which the bench reads from `lba_addr`. The same method shows that writes made in 28-bit or undefined modes leave the 48-bit state alone.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned NUM_PAIRS = 4;
    localparam int unsigned LBA48_W   = 2 * (NUM_PAIRS - 1) * BYTE_W;
    localparam int unsigned CNT16_W   = 2 * BYTE_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_COUNT   = 3'd0,
        SEL_SECNUM  = 3'd1,
        SEL_CYLLO   = 3'd2,
        SEL_CYLHI   = 3'd3,
        SEL_DEVHEAD = 3'd4
    } tf_sel_e;

    typedef struct packed {
        logic chs;
        logic lba28;
        logic lba48;
    } tf_mode_t;

    function automatic tf_mode_t decode_mode(input logic [BYTE_W-1:0] dh);
        tf_mode_t m;
        m.chs   = ~dh[6];
        m.lba28 = dh[6] &  dh[7] &  dh[5];
        m.lba48 = dh[6] & ~dh[7] & ~dh[5];
        return m;
    endfunction

endpackage

// File: rtl/ata_tf_legacy.sv
module ata_tf_legacy
    import ata_tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] count_q,
    output logic [BYTE_W-1:0] secnum_q,
    output logic [BYTE_W-1:0] cyllo_q,
    output logic [BYTE_W-1:0] cylhi_q,
    output logic [BYTE_W-1:0] devhead_q,
    output logic              mode_bits_change
);

    typedef struct packed {
        logic [BYTE_W-1:0] count;
        logic [BYTE_W-1:0] secnum;
        logic [BYTE_W-1:0] cyllo;
        logic [BYTE_W-1:0] cylhi;
        logic [BYTE_W-1:0] devhead;
    } legacy_t;

    legacy_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_sel)
                SEL_COUNT:   st_d.count   = wr_data;
                SEL_SECNUM:  st_d.secnum  = wr_data;
                SEL_CYLLO:   st_d.cyllo   = wr_data;
                SEL_CYLHI:   st_d.cylhi   = wr_data;
                SEL_DEVHEAD: st_d.devhead = wr_data;
                default:     st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count_q   = st_q.count;
    assign secnum_q  = st_q.secnum;
    assign cyllo_q   = st_q.cyllo;
    assign cylhi_q   = st_q.cylhi;
    assign devhead_q = st_q.devhead;

    assign mode_bits_change = wr_en && (reg_sel == SEL_DEVHEAD) &&
                              (wr_data[7:5] != st_q.devhead[7:5]);

    // R2
    legacy_count_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == SEL_COUNT) |=> (count_q == $past(wr_data)));

    // R2
    legacy_unused_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel > SEL_DEVHEAD) |=>
            ($stable(count_q) && $stable(secnum_q) && $stable(cyllo_q) &&
             $stable(cylhi_q) && $stable(devhead_q)));

endmodule

// File: rtl/ata_tf_twostep.sv
module ata_tf_twostep
    import ata_tf_pkg::*;
#(
    parameter bit CLR_SECOND_ON_FIRST = 1'b0,
    parameter bit CLR_ON_CMD          = 1'b1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              tog_clr,
    input  logic              cmd_clr,
    input  logic [BYTE_W-1:0] din,
    output logic              tog_q,
    output logic [BYTE_W-1:0] first_q,
    output logic [BYTE_W-1:0] second_q
);

    typedef struct packed {
        logic              tog;
        logic [BYTE_W-1:0] first;
        logic [BYTE_W-1:0] second;
    } pair_t;

    pair_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (CLR_ON_CMD && cmd_clr) begin
            st_d.first  = '0;
            st_d.second = '0;
        end
        if (tog_clr) begin
            st_d.tog = 1'b0;
        end
        if (wr_en) begin
            if (!st_q.tog) begin
                st_d.first = din;
                if (CLR_SECOND_ON_FIRST) begin
                    st_d.second = '0;
                end
            end else begin
                st_d.second = din;
            end
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tog_q    = st_q.tog;
    assign first_q  = st_q.first;
    assign second_q = st_q.second;

    // R5
    tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !tog_clr) |=> $stable(tog_q));

    // R4
    first_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !tog_q) |=> (tog_q && first_q == $past(din)));

    // R4
    second_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tog_q) |=> (!tog_q && second_q == $past(din)));

endmodule

// File: rtl/ata_lba_capture.sv
module ata_lba_capture
    import ata_tf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                cmd_strobe,
    output logic                mode_chs,
    output logic                mode_lba28,
    output logic                mode_lba48,
    output logic [LBA48_W-1:0]  lba_addr,
    output logic [CNT16_W-1:0]  sect_count16,
    output logic [CNT16_W:0]    xfer_sectors,
    output logic [BYTE_W-1:0]   count_byte,
    output logic [BYTE_W-1:0]   secnum_byte,
    output logic [BYTE_W-1:0]   cyl_lo_byte,
    output logic [BYTE_W-1:0]   cyl_hi_byte,
    output logic [BYTE_W-1:0]   devhead_byte
);

    localparam int unsigned LBA28_PAD = LBA48_W - 28;

    logic [BYTE_W-1:0] cnt_b, sec_b, clo_b, chi_b, dh_b;
    logic              mode_chg;
    tf_mode_t          mode;

    logic [NUM_PAIRS-1:0] tog;
    logic [BYTE_W-1:0]    first_b  [NUM_PAIRS];
    logic [BYTE_W-1:0]    second_b [NUM_PAIRS];

    logic [LBA48_W-1:0] lba48_val;

    ata_tf_legacy legacy_i (
        .clk              (clk),
        .rst              (rst),
        .wr_en            (wr_en),
        .reg_sel          (reg_sel),
        .wr_data          (wr_data),
        .count_q          (cnt_b),
        .secnum_q         (sec_b),
        .cyllo_q          (clo_b),
        .cylhi_q          (chi_b),
        .devhead_q        (dh_b),
        .mode_bits_change (mode_chg)
    );

    always_comb mode = decode_mode(dh_b);

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        logic hit;
        assign hit = wr_en && mode.lba48 && (reg_sel == SEL_W'(i));
        ata_tf_twostep #(
            .CLR_SECOND_ON_FIRST (i == 0),
            .CLR_ON_CMD          (i != 0)
        ) pair_i (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (hit),
            .tog_clr  (mode_chg),
            .cmd_clr  (cmd_strobe),
            .din      (wr_data),
            .tog_q    (tog[i]),
            .first_q  (first_b[i]),
            .second_q (second_b[i])
        );
    end

    always_comb begin
        lba48_val    = {first_b[3], first_b[2], first_b[1],
                        second_b[3], second_b[2], second_b[1]};
        sect_count16 = {first_b[0], second_b[0]};
        mode_chs     = mode.chs;
        mode_lba28   = mode.lba28;
        mode_lba48   = mode.lba48;
        if (mode.lba48)
            lba_addr = lba48_val;
        else if (mode.lba28)
            lba_addr = {{LBA28_PAD{1'b0}}, dh_b[3:0], chi_b, clo_b, sec_b};
        else
            lba_addr = '0;
        if (mode.lba48)
            xfer_sectors = (sect_count16 == '0) ? (CNT16_W+1)'(1 << CNT16_W)
                                                : {1'b0, sect_count16};
        else
            xfer_sectors = (cnt_b == '0) ? (CNT16_W+1)'(1 << BYTE_W)
                                         : (CNT16_W+1)'(cnt_b);
        count_byte   = cnt_b;
        secnum_byte  = sec_b;
        cyl_lo_byte  = clo_b;
        cyl_hi_byte  = chi_b;
        devhead_byte = dh_b;
    end

    // R6
    tog_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == SEL_DEVHEAD && wr_data[7:5] != devhead_byte[7:5])
            |=> (tog == '0));

    // R7
    lba_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && !(wr_en && mode_lba48 && reg_sel >= SEL_SECNUM &&
                         reg_sel <= SEL_CYLHI)) |=> (lba48_val == '0));

    // R7
    count_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && !(wr_en && reg_sel == SEL_COUNT)) |=> $stable(sect_count16));

    // R1
    mode_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mode_chs, mode_lba28, mode_lba48}));

endmodule

// File: tb/ata_lba_capture_tb.sv
module ata_lba_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        cmd_strobe = 1'b0;
    logic        mode_chs, mode_lba28, mode_lba48;
    logic [47:0] lba_addr;
    logic [15:0] sect_count16;
    logic [16:0] xfer_sectors;
    logic [7:0]  count_byte, secnum_byte, cyl_lo_byte, cyl_hi_byte, devhead_byte;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ata_lba_capture dut_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .reg_sel      (reg_sel),
        .wr_data      (wr_data),
        .cmd_strobe   (cmd_strobe),
        .mode_chs     (mode_chs),
        .mode_lba28   (mode_lba28),
        .mode_lba48   (mode_lba48),
        .lba_addr     (lba_addr),
        .sect_count16 (sect_count16),
        .xfer_sectors (xfer_sectors),
        .count_byte   (count_byte),
        .secnum_byte  (secnum_byte),
        .cyl_lo_byte  (cyl_lo_byte),
        .cyl_hi_byte  (cyl_hi_byte),
        .devhead_byte (devhead_byte)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmd_pulse();
        @(negedge clk);
        cmd_strobe = 1'b1;
        @(negedge clk);
        cmd_strobe = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 mode_chs", mode_chs, 1);
        chk("R10 lba", lba_addr, 0);
        chk("R10 xfer 256", xfer_sectors, 256);
        chk("R10 devhead", devhead_byte, 0);
        chk("R10 count16", sect_count16, 0);
    endtask

    task automatic t_mode_decode();
        wr(3'd4, 8'hE0);
        chk("R1 lba28", {mode_chs, mode_lba28, mode_lba48}, 3'b010);
        wr(3'd4, 8'h40);
        chk("R1 lba48", {mode_chs, mode_lba28, mode_lba48}, 3'b001);
        wr(3'd4, 8'hC0);
        chk("R1 undefined", {mode_chs, mode_lba28, mode_lba48}, 3'b000);
        wr(3'd4, 8'hB0);
        chk("R1 chs", {mode_chs, mode_lba28, mode_lba48}, 3'b100);
    endtask

    task automatic t_legacy();
        wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h33); wr(3'd3, 8'h44);
        chk("R2 copies", {count_byte, secnum_byte, cyl_lo_byte, cyl_hi_byte}, 32'h11223344);
        for (int s = 5; s < 8; s++) wr(3'(s), 8'hFF);
        chk("R2 unused sel", {count_byte, secnum_byte, cyl_lo_byte, cyl_hi_byte, devhead_byte},
            40'h11223344B0);
    endtask

    task automatic t_lba48();
        wr(3'd4, 8'h40);
        wr(3'd0, 8'h12); wr(3'd0, 8'h34);
        chk("R3 count pair", sect_count16, 16'h1234);
        wr(3'd1, 8'hA1); wr(3'd2, 8'hB2); wr(3'd3, 8'hC3);
        wr(3'd1, 8'hD4); wr(3'd2, 8'hE5); wr(3'd3, 8'hF6);
        chk("R4 lba48", lba_addr, 48'hC3B2A1F6E5D4);
        chk("R2 copy in lba48", secnum_byte, 8'hD4);
        wr(3'd0, 8'h56);
        chk("R3 first clears low", sect_count16, 16'h5600);
        wr(3'd0, 8'h00);
        chk("R3 second low", sect_count16, 16'h5600);
        wr(3'd0, 8'h00); wr(3'd0, 8'h00);
        chk("R9 lba48 zero count", xfer_sectors, 17'd65536);
        wr(3'd0, 8'h00); wr(3'd0, 8'h09);
        chk("R9 lba48 count", xfer_sectors, 17'd9);
    endtask

    task automatic t_cmd_clear();
        cmd_pulse();
        chk("R7 lba cleared", lba_addr, 0);
        chk("R7 count kept", sect_count16, 16'h0009);
        @(negedge clk);
        cmd_strobe = 1'b1; wr_en = 1'b1; reg_sel = 3'd2; wr_data = 8'h5A;
        @(negedge clk);
        cmd_strobe = 1'b0; wr_en = 1'b0;
        chk("R7 write after clear", lba_addr, 48'h005A00000000);
        wr(3'd2, 8'h00);
        cmd_pulse();
    endtask

    task automatic t_toggle_clear();
        wr(3'd1, 8'h11);
        wr(3'd4, 8'h50);
        wr(3'd1, 8'h22);
        chk("R6 same mode bits keep toggle", lba_addr, 48'h000011000022);
        wr(3'd1, 8'h33);
        wr(3'd4, 8'hE0);
        wr(3'd4, 8'h40);
        wr(3'd1, 8'h44);
        chk("R6 mode change clears toggle", lba_addr, 48'h000044000022);
        wr(3'd1, 8'h55);
        chk("R6 pair resumes", lba_addr, 48'h000044000055);
    endtask

    task automatic t_mode_ignore();
        wr(3'd4, 8'hE0);
        wr(3'd1, 8'h99); wr(3'd0, 8'h77);
        wr(3'd4, 8'hC0);
        wr(3'd3, 8'h88);
        wr(3'd4, 8'h40);
        chk("R5 lba48 untouched", lba_addr, 48'h000044000055);
        chk("R5 count untouched", sect_count16, 16'h0009);
        wr(3'd2, 8'h66);
        chk("R5 toggle untouched", lba_addr, 48'h006644000055);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_lba28();
        wr(3'd4, 8'hE5);
        wr(3'd1, 8'h78); wr(3'd2, 8'h56); wr(3'd3, 8'h34);
        chk("R8 lba28 addr", lba_addr, 48'h000005345678);
        wr(3'd0, 8'h00);
        chk("R9 lba28 zero count", xfer_sectors, 17'd256);
        wr(3'd0, 8'h07);
        chk("R9 lba28 count", xfer_sectors, 17'd7);
        wr(3'd4, 8'hA5);
        chk("R8 chs addr zero", lba_addr, 0);
        wr(3'd4, 8'hC5);
        chk("R8 undefined addr zero", lba_addr, 0);
    endtask

    task automatic t_reset_mid();
        wr(3'd4, 8'h40);
        wr(3'd3, 8'hAB);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R10 reset devhead", devhead_byte, 0);
        chk("R10 reset cylhi", cyl_hi_byte, 0);
        wr(3'd4, 8'h40);
        chk("R10 reset lba48", lba_addr, 0);
        wr(3'd3, 8'hCD);
        chk("R10 reset toggle", lba_addr, 48'hCD0000000000);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode_decode();
        t_legacy();
        t_lba48();
        t_cmd_clear();
        t_toggle_clear();
        t_mode_ignore();
        t_lba28();
        t_reset_mid();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule